// File: doc/BRIEF.md
# PLL Stepped Sweep Sequencer

This block steps a phase-locked loop through a frequency sweep by rewriting the division factor of the loop's programmable divider. Each sweep has a fixed number of equal-length steps. An interval timer sets how long each step lasts. On every step the block adds a programmed increment to the running division factor and raises a step pulse. It also advances a 6-bit staircase code, which an external binary-weighted resistor network turns into a ramp voltage. One unit of increment is one divider count, which is 1 kHz of output frequency.

After the last step the block enters a fixed fly-back interval of 200 ms, counted in system-clock cycles. During fly-back the sync output is high, the staircase code sits at zero, and the division factor follows the start value so that the loop can settle. Fly-back also serves as the master clear after reset.

A load-clock enable runs at the system clock divided by `LOAD_DIV`. Each new division factor is announced by a one-cycle load request, which is issued together with the next load-clock enable. Increment and step period are clamped and then captured when a sweep begins. Dropping the enable input parks the block with the divider at the start value.

Top module: `sweep_step_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after a clock edge with `rst` high, the outputs read `sync`=1, `stair`=0, `div_out`=0, `step_pulse`=0, `load_req`=0 and `load_ce`=0.
- R2: Fly-back lasts exactly `CLK_HZ/1000*FLY_MS` cycles with `sync` high. During fly-back `stair` is 0 and `div_out` equals the `start_div` presented in the previous cycle.
- R3: In a sweep, `step_pulse` is high for one cycle after every P cycles, where P is the clamped period captured at sweep start. The first pulse comes P cycles after the sweep begins.
- R4: On steps 1 to STEPS-1, `div_out` grows by the captured increment, modulo 2^DIV_W, in the same cycle as `step_pulse`.
- R5: `stair` is 0 at sweep start and rises by 1 with each of steps 1 to STEPS-1, so it takes the values 0 to STEPS-1.
- R6: Step STEPS ends the sweep. In the cycle of its pulse, `sync` rises, `stair` returns to 0 and `div_out` returns to `start_div`. Every uninterrupted sweep has exactly STEPS pulses.
- R7: The step period is clamped to the range [max(1,CLK_HZ/1000), CLK_HZ*2/5] cycles, which is 0.05 s to 20 s per sweep.
- R8: The increment is clamped to the range [1, INC_MAX]. With `step_inc`=0 the increment is 1.
- R9: Increment and period are captured only when a sweep starts. Changes made mid-sweep do not affect `div_out` or step timing until the next sweep.
- R10: While `en` is low, from the next cycle on: `sync`=0, `stair`=0, no step pulses, and `div_out` equals the previous cycle's `start_div`. On the first cycle with `en` high a sweep starts at once, without fly-back.
- R11: `load_ce` pulses for one cycle every LOAD_DIV cycles, the first one LOAD_DIV cycles after reset. `load_req` is high only together with `load_ce`, and only when `div_out` has changed since the previous `load_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sweep enable; when low the block parks at the start factor |
| start_div | input | DIV_W | Division factor for the sweep start frequency |
| step_inc | input | INC_W | Division-factor increment per step (1 kHz per unit) |
| step_period | input | TMR_W | Step length in clock cycles, i.e. sweep time / STEPS |
| div_out | output | DIV_W | Division factor presented to the PLL divider |
| load_req | output | 1 | One-cycle request to load `div_out` into the divider |
| load_ce | output | 1 | Load-clock enable, one cycle every LOAD_DIV cycles |
| stair | output | STAIR_W | Staircase code for the weighted-resistor DAC |
| step_pulse | output | 1 | One-cycle pulse on every step |
| sync | output | 1 | High during fly-back |

## Verification
A wrong step-timer or fly-back count shows up as a `step_pulse` or a `sync` edge that arrives a cycle early or late. A cycle-accurate model catches it on the first affected edge. A corrupted accumulator or staircase value appears on `div_out` or `stair` in the same cycle as the faulty step. Missed latching of the increment or period shows up at the next step after a mid-sweep write. An error in the load pacing shows within one load period, as a `load_req` that is missing or misplaced relative to `load_ce`.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_RUN  = 2'd1,
    SW_FLY  = 2'd2
  } sweep_state_e;

endpackage

// File: rtl/sweep_param_latch.sv
// Clamps the increment and step period to their legal ranges and captures
// them when a sweep begins.
module sweep_param_latch #(
  parameter int INC_W   = 10,
  parameter int INC_MAX = 1000,
  parameter int TMR_W   = 24,
  parameter int MIN_PER = 3000,
  parameter int MAX_PER = 1200000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [INC_W-1:0] inc_in,
  input  logic [TMR_W-1:0] per_in,
  output logic [INC_W-1:0] inc_q,
  output logic [TMR_W-1:0] per_q
);

  localparam logic [INC_W-1:0] INC_LO = INC_W'(1);
  localparam logic [INC_W-1:0] INC_HI = INC_W'(INC_MAX);
  localparam logic [TMR_W-1:0] PER_LO = TMR_W'(MIN_PER);
  localparam logic [TMR_W-1:0] PER_HI = TMR_W'(MAX_PER);

  logic [INC_W-1:0] inc_c;
  logic [TMR_W-1:0] per_c;

  always_comb begin
    inc_c = inc_in;
    if (inc_in < INC_LO)      inc_c = INC_LO;
    else if (inc_in > INC_HI) inc_c = INC_HI;
  end

  always_comb begin
    per_c = per_in;
    if (per_in < PER_LO)      per_c = PER_LO;
    else if (per_in > PER_HI) per_c = PER_HI;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q <= INC_LO;
      per_q <= PER_LO;
    end else if (take) begin
      inc_q <= inc_c;
      per_q <= per_c;
    end
  end

  AST_INC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (inc_q >= INC_LO) && (inc_q <= INC_HI)); // R8
  AST_PER_RANGE: assert property (@(posedge clk) disable iff (rst)
    (per_q >= PER_LO) && (per_q <= PER_HI)); // R7
  AST_HOLD_MIDSWEEP: assert property (@(posedge clk) disable iff (rst)
    !take |=> ($stable(inc_q) && $stable(per_q))); // R9

endmodule

// File: rtl/sweep_cycle_timer.sv
// Counts run cycles and flags the last cycle of each interval of LIMIT cycles.
module sweep_cycle_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         expire
);

  logic [W-1:0] cnt;

  assign expire = run && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (expire)  cnt <= '0;
    else if (run)     cnt <= cnt + W'(1);
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit)); // R3

endmodule

// File: rtl/sweep_div_accum.sv
// Holds the division factor: it can load a start value or add an increment.
module sweep_div_accum #(
  parameter int DIV_W = 20,
  parameter int INC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [DIV_W-1:0] ld_val,
  input  logic             add,
  input  logic [INC_W-1:0] add_val,
  output logic [DIV_W-1:0] q,
  output logic             chg
);

  logic [DIV_W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (ld)       nxt = ld_val;
    else if (add) nxt = q + DIV_W'(add_val);
  end

  assign chg = (nxt != q);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

endmodule

// File: rtl/sweep_load_pacer.sv
// Divides the system clock into a load-clock enable, and turns factor
// changes into a load request aligned to that enable.
module sweep_load_pacer #(
  parameter int LOAD_DIV = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic div_chg,
  output logic load_ce,
  output logic load_req
);

  localparam int P_W = (LOAD_DIV > 1) ? $clog2(LOAD_DIV) : 1;

  logic [P_W-1:0] phase;
  logic           tick;
  logic           pend;

  assign tick = (phase == P_W'(LOAD_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      pend     <= 1'b0;
      load_ce  <= 1'b0;
      load_req <= 1'b0;
    end else begin
      phase    <= tick ? '0 : phase + P_W'(1);
      load_ce  <= tick;
      load_req <= tick && pend;
      pend     <= (pend && !tick) || div_chg;
    end
  end

  AST_REQ_ON_CE: assert property (@(posedge clk) disable iff (rst)
    load_req |-> load_ce); // R11
  AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    load_ce |=> !load_ce); // R11

endmodule

// File: rtl/sweep_step_seq.sv
module sweep_step_seq
  import sweep_pkg::*;
#(
  parameter int CLK_HZ   = 3000000,
  parameter int FLY_MS   = 200,
  parameter int STEPS    = 50,
  parameter int DIV_W    = 20,
  parameter int INC_W    = 10,
  parameter int INC_MAX  = 1000,
  parameter int TMR_W    = 24,
  parameter int LOAD_DIV = 23,
  localparam int STAIR_W = $clog2(STEPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DIV_W-1:0]   start_div,
  input  logic [INC_W-1:0]   step_inc,
  input  logic [TMR_W-1:0]   step_period,
  output logic [DIV_W-1:0]   div_out,
  output logic               load_req,
  output logic               load_ce,
  output logic [STAIR_W-1:0] stair,
  output logic               step_pulse,
  output logic               sync
);

  localparam int MIN_PER_RAW = CLK_HZ / 1000;
  localparam int MIN_PER     = (MIN_PER_RAW < 1) ? 1 : MIN_PER_RAW;
  localparam int MAX_PER_RAW = (CLK_HZ / 5) * 2;
  localparam int MAX_PER     = (MAX_PER_RAW < MIN_PER) ? MIN_PER : MAX_PER_RAW;
  localparam int FLY_RAW     = (CLK_HZ / 1000) * FLY_MS;
  localparam int FLY_CYC     = (FLY_RAW < 1) ? 1 : FLY_RAW;
  localparam int FLY_W       = $clog2(FLY_CYC + 1);
  localparam logic [STAIR_W-1:0] LAST = STAIR_W'(STEPS - 1);

  sweep_state_e     state;
  logic [INC_W-1:0] inc_q;
  logic [TMR_W-1:0] per_q;
  logic             step_exp;
  logic             fly_done;
  logic             take;
  logic             is_run;
  logic             is_fly;
  logic             final_step;
  logic             div_ld;
  logic             div_add;
  logic             div_chg;

  assign is_run     = en && (state == SW_RUN);
  assign is_fly     = en && (state == SW_FLY);
  assign take       = en && ((state == SW_IDLE) || fly_done);
  assign final_step = step_exp && (stair == LAST);
  assign div_ld     = !is_run || final_step;
  assign div_add    = step_exp && !final_step;
  assign sync       = (state == SW_FLY);

  sweep_param_latch #(
    .INC_W   (INC_W),
    .INC_MAX (INC_MAX),
    .TMR_W   (TMR_W),
    .MIN_PER (MIN_PER),
    .MAX_PER (MAX_PER)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .take   (take),
    .inc_in (step_inc),
    .per_in (step_period),
    .inc_q  (inc_q),
    .per_q  (per_q)
  );

  sweep_cycle_timer #(.W(TMR_W)) u_step_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (!is_run),
    .run    (is_run),
    .limit  (per_q),
    .expire (step_exp)
  );

  sweep_cycle_timer #(.W(FLY_W)) u_fly_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (!is_fly),
    .run    (is_fly),
    .limit  (FLY_W'(FLY_CYC)),
    .expire (fly_done)
  );

  sweep_div_accum #(.DIV_W(DIV_W), .INC_W(INC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .ld      (div_ld),
    .ld_val  (start_div),
    .add     (div_add),
    .add_val (inc_q),
    .q       (div_out),
    .chg     (div_chg)
  );

  sweep_load_pacer #(.LOAD_DIV(LOAD_DIV)) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .div_chg  (div_chg),
    .load_ce  (load_ce),
    .load_req (load_req)
  );

  // Sequencing: reset enters fly-back, which doubles as the master clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SW_FLY;
      stair      <= '0;
      step_pulse <= 1'b0;
    end else begin
      step_pulse <= step_exp;
      if (!en) begin
        state <= SW_IDLE;
        stair <= '0;
      end else begin
        unique case (state)
          SW_IDLE: begin
            state <= SW_RUN;
            stair <= '0;
          end
          SW_FLY: begin
            stair <= '0;
            if (fly_done) state <= SW_RUN;
          end
          SW_RUN: begin
            if (final_step) begin
              state <= SW_FLY;
              stair <= '0;
            end else if (step_exp) begin
              stair <= stair + STAIR_W'(1);
            end
          end
          default: state <= SW_IDLE;
        endcase
      end
    end
  end

  AST_STAIR_RANGE: assert property (@(posedge clk) disable iff (rst)
    stair <= LAST); // R5
  AST_STAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && state == SW_RUN) |-> (stair == $past(stair) + STAIR_W'(1))); // R5
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    (step_pulse && state == SW_RUN) |->
      (div_out == $past(div_out) + DIV_W'($past(inc_q)))); // R4
  AST_FLY_ZERO: assert property (@(posedge clk) disable iff (rst)
    sync |-> (stair == '0)); // R2
  AST_END_TO_FLY: assert property (@(posedge clk) disable iff (rst)
    (final_step && en) |=> (sync && step_pulse && stair == '0)); // R6
  AST_PARK: assert property (@(posedge clk) disable iff (rst)
    !en |=> (state == SW_IDLE && stair == '0 && !step_pulse)); // R10

endmodule

// File: tb/tb_sweep_step_seq.sv
module tb_sweep_step_seq;

  localparam int CLK_HZ = 1000;
  localparam int FLY    = 200;
  localparam int STEPS  = 50;
  localparam int DIV_W  = 20;
  localparam int INC_W  = 10;
  localparam int TMR_W  = 24;
  localparam int LD     = 23;
  localparam int MINP   = 1;
  localparam int MAXP   = 400;
  localparam int MASK   = (1 << DIV_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en  = 1'b0;
  logic [DIV_W-1:0] start_div = '0;
  logic [INC_W-1:0] step_inc = '0;
  logic [TMR_W-1:0] step_period = '0;
  logic [DIV_W-1:0] div_out;
  logic             load_req, load_ce, step_pulse, sync;
  logic [5:0]       stair;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  sweep_step_seq #(.CLK_HZ(CLK_HZ), .STEPS(STEPS), .DIV_W(DIV_W),
                   .INC_W(INC_W), .TMR_W(TMR_W), .LOAD_DIV(LD)) dut (
    .clk(clk), .rst(rst), .en(en), .start_div(start_div),
    .step_inc(step_inc), .step_period(step_period), .div_out(div_out),
    .load_req(load_req), .load_ce(load_ce), .stair(stair),
    .step_pulse(step_pulse), .sync(sync)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual %0d expected %0d", tag, phase, act, exp);
    end
  endtask

  // Behavioural reference: 0 idle, 1 run, 2 fly-back
  int m_st, m_fly, m_tmr, m_stair, m_div, m_per, m_inc, m_p;
  bit m_sp, m_pend, m_ce, m_req;

  always @(posedge clk) begin
    int pc, ic, old;
    bit tick;
    pc = step_period;
    if (pc < MINP) pc = MINP;
    if (pc > MAXP) pc = MAXP;
    ic = step_inc;
    if (ic < 1) ic = 1;
    if (ic > 1000) ic = 1000;
    if (rst) begin
      m_st = 2; m_fly = 0; m_tmr = 0; m_stair = 0; m_div = 0; m_sp = 0;
      m_per = MINP; m_inc = 1; m_p = 0; m_pend = 0; m_ce = 0; m_req = 0;
    end else begin
      tick = (m_p == LD - 1);
      old  = m_div;
      m_sp = 0;
      if (!en) begin
        m_st = 0; m_div = start_div; m_stair = 0; m_tmr = 0; m_fly = 0;
      end else if (m_st == 0) begin
        m_per = pc; m_inc = ic; m_div = start_div; m_tmr = 0; m_stair = 0; m_st = 1;
      end else if (m_st == 2) begin
        m_div = start_div; m_stair = 0;
        if (m_fly == FLY - 1) begin
          m_per = pc; m_inc = ic; m_st = 1; m_fly = 0; m_tmr = 0;
        end else m_fly++;
      end else begin
        if (m_tmr == m_per - 1) begin
          m_tmr = 0; m_sp = 1;
          if (m_stair == STEPS - 1) begin
            m_st = 2; m_fly = 0; m_stair = 0; m_div = start_div;
          end else begin
            m_stair++; m_div = (m_div + m_inc) & MASK;
          end
        end else m_tmr++;
      end
      m_req  = tick && m_pend;
      m_ce   = tick;
      m_pend = (m_pend && !tick) || (m_div != old);
      m_p    = tick ? 0 : m_p + 1;
    end
  end

  // Compare on every falling edge
  int  sweep_steps = 0;
  bit  sweep_valid = 0;
  bit  prev_sync   = 1;
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R4 div_out", div_out, m_div);
      check("R5 stair", stair, m_stair);
      check("R3 step_pulse", step_pulse, m_sp);
      check("R2 sync", sync, m_st == 2);
      check("R11 load_ce", load_ce, m_ce);
      check("R11 load_req", load_req, m_req);
      if (step_pulse) sweep_steps++;
      if (sync && !prev_sync) begin
        if (sweep_valid) check("R6 steps per sweep", sweep_steps, STEPS);
        sweep_valid = 0;
      end
      if (!sync && prev_sync) begin
        sweep_valid = 1; sweep_steps = 0;
      end
      if (!en) sweep_valid = 0;
      prev_sync = sync;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    start_div = 20'd1000; step_inc = 10'd5; step_period = 24'd2;
    wait_cycles(4);
    // R1: state under reset
    check("R1 sync", sync, 1);
    check("R1 stair", stair, 0);
    check("R1 div_out", div_out, 0);
    check("R1 step_pulse", step_pulse, 0);
    check("R1 load_req", load_req, 0);
    check("R1 load_ce", load_ce, 0);
    rst = 1'b0; en = 1'b1;
    // R2 R3 R4 R5 R6 R11: fly-back, then full sweeps
    phase = "R2 R3 R4 R5 R6 R11";
    wait_cycles(650);
    // R9: mid-sweep writes wait for the next sweep
    phase = "R9";
    step_inc = 10'd9; step_period = 24'd3;
    wait_cycles(900);
    // R8 R7 lower clamps
    phase = "R7 R8 low";
    step_inc = 10'd0; step_period = 24'd0;
    wait_cycles(600);
    // R8 R7 upper clamps: a 400-cycle step, full sweep
    phase = "R7 R8 high";
    step_inc = 10'd1023; step_period = 24'd1000;
    wait_cycles(20800);
    // R10: parked while enable is low, then immediate restart with wrap
    phase = "R10";
    en = 1'b0;
    wait_cycles(20);
    start_div = 20'hFFF00; step_inc = 10'd1000; step_period = 24'd1;
    wait_cycles(20);
    check("R10 parked div", div_out, 20'hFFF00);
    check("R10 parked stair", stair, 0);
    check("R10 parked sync", sync, 0);
    en = 1'b1;
    wait_cycles(400);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog [%s] actual %0d expected %0d", phase, cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule